// File: doc/BRIEF.md
# Multi-lane pixel deserializer with parity

This block rebuilds a parallel video pixel from a serial stream carried on one, two or three data lanes. All lanes share a single bit-rate clock. A frame strobe marks the first bit time of every 30-bit frame. The active lanes split the frame evenly between them. Once the last bit time of a frame has been sampled, the block checks two things: the frame's even parity and its two fixed marker bits.

When a frame passes both checks, the block updates a 27-bit parallel word: 24 colour bits plus vertical sync, horizontal sync and data enable. It also emits a one-cycle pixel strobe. When a frame fails, the block keeps the previous word on the bus, raises an error flag and still emits the pixel strobe.

A swap input mirrors the colour bus so that the board layout can run in either direction. A clock-loss input forces a fixed idle pattern. After clock loss ends, the block waits for a complete new frame before it emits another pixel strobe.

Top module: `pxd_deserializer`

## Requirements
- R1: The lane-select code sets the number of active lanes, and with it the number of bit times N per frame. Code 00 gives one lane with N=30, 01 gives two lanes with N=15, and both 10 and 11 give three lanes with N=10. Lane k carries frame bits k*N up to k*N+N-1, most significant first. The first bit is sampled on the clock edge where frame_start is high.
- R2: Frame bit layout: bits 23:16 red, 15:8 green, 7:0 blue, 24 DE, 25 HS, 26 VS, 27 parity, 28 marker (must be 0) and 29 marker (must be 1). A frame is valid when bits 27:0 hold an even number of ones and both markers are correct. A valid frame replaces the output word and drives parity_err low.
- R3: An invalid frame leaves pix_out, vs, hs and de unchanged and drives parity_err high. parity_err changes only when pclk_en is high, when clk_lost is active or at reset.
- R4: Results appear on the clock edge after the edge that samples a frame's last bit. On that same edge pclk_en goes high for exactly one cycle, for valid and invalid frames alike.
- R5: With swap high, pix_out[i] equals colour word bit 23-i, which reverses each colour byte and exchanges red and blue. vs, hs and de are unaffected. swap acts without a clock edge.
- R6: While clk_lost is high, from the next clock edge onward: pclk_en, de and parity_err are low, and pix_out, vs and hs are all ones. A frame strobe in this state has no effect.
- R7: After clk_lost falls, serial bits arriving without a frame strobe produce no pclk_en. The first pulse follows a strobe plus a complete frame.
- R8: A change of lane_sel after the frame strobe does not alter how the current frame is split. The new code is taken at the next strobe.
- R9: A frame strobe that arrives while a frame is still being collected restarts collection. The partial frame produces no pclk_en.
- R10: A synchronous active-high reset puts the outputs into the R6 idle state with pclk_en low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_lost | input | 1 | Incoming clock absent; forces idle outputs |
| lane_sel | input | 2 | Active lane count code |
| frame_start | input | 1 | High during the first bit time of a frame |
| sd | input | 3 | Serial data, one bit per lane |
| swap | input | 1 | Mirror the colour bus |
| pix_out | output | 24 | Colour bits, red in the top byte when swap is low |
| vs | output | 1 | Vertical sync |
| hs | output | 1 | Horizontal sync |
| de | output | 1 | Data enable |
| pclk_en | output | 1 | One-cycle pulse per received frame |
| parity_err | output | 1 | Most recent frame failed its checks |

## Verification
The bench sends frames in every lane mode, including code 11. If lane slicing or bit order were wrong, every colour would come out scrambled.

Damaged frames come in two kinds: a flipped parity bit and a wrong marker bit. A design that let a damaged frame through would overwrite the held word. A design that skipped the pixel strobe on an error would stop pacing the display.

Further directed cases cover:
- a lane-select change in mid-frame, which a careless design would apply at once and so misplace the remaining bits;
- a strobe that cuts a frame short, where a design could emit a pulse for the fragment;
- serial bits after clock loss with no strobe, where a design could resume on stale alignment.

The bench also flips swap on a held word to show that the mirror is combinational and leaves the control bits untouched.

// File: rtl/pxd_pkg.sv
package pxd_pkg;

    localparam int FRAME_W   = 30;
    localparam int PIX_W     = 24;
    localparam int MAX_LANES = 3;
    localparam int LSEL_W    = $clog2(MAX_LANES + 1);
    localparam int CNT_W     = $clog2(FRAME_W + 1);

    // Frame bit positions decoded downstream
    localparam int BIT_DE  = 24;
    localparam int BIT_HS  = 25;
    localparam int BIT_VS  = 26;
    localparam int BIT_PAR = 27;
    localparam int BIT_M0  = 28;
    localparam int BIT_M1  = 29;

    typedef logic [FRAME_W-1:0] frame_t;

    typedef struct packed {
        logic             vs;
        logic             hs;
        logic             de;
        logic [PIX_W-1:0] rgb;
    } word_t;

    localparam word_t IDLE_WORD = '{vs: 1'b1, hs: 1'b1, de: 1'b0, rgb: '1};

    // Offset of lane k inside the packed vector of all lane shift registers
    function automatic int lane_off(input int k);
        int s = 0;
        for (int j = 0; j < k; j++) s += FRAME_W / (j + 1);
        return s;
    endfunction

    localparam int TOT_LANE_BITS = lane_off(MAX_LANES);

    // Lane-select code -> mode index (mode m means m+1 lanes)
    function automatic logic [LSEL_W-1:0] mode_of(input logic [LSEL_W-1:0] sel);
        if (int'(sel) >= MAX_LANES) return LSEL_W'(MAX_LANES - 1);
        return sel;
    endfunction

    function automatic logic [CNT_W-1:0] bits_per_lane(input logic [LSEL_W-1:0] mode);
        logic [CNT_W-1:0] r = CNT_W'(FRAME_W);
        for (int m = 0; m < MAX_LANES; m++)
            if (int'(mode) == m) r = CNT_W'(FRAME_W / (m + 1));
        return r;
    endfunction

    function automatic logic frame_ok(input frame_t f);
        return (^f[BIT_PAR:0] == 1'b0) && f[BIT_M1] && !f[BIT_M0];
    endfunction

    function automatic word_t decode(input frame_t f);
        word_t w;
        w.rgb = f[PIX_W-1:0];
        w.de  = f[BIT_DE];
        w.hs  = f[BIT_HS];
        w.vs  = f[BIT_VS];
        return w;
    endfunction

    function automatic logic [PIX_W-1:0] mirror(input logic [PIX_W-1:0] x);
        logic [PIX_W-1:0] r;
        for (int i = 0; i < PIX_W; i++) r[i] = x[PIX_W-1-i];
        return r;
    endfunction

endpackage

// File: rtl/pxd_lane_shift.sv
module pxd_lane_shift #(
    parameter int W = 30
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sd_i,
    output logic [W-1:0] sr_o
);

    always_ff @(posedge clk) begin
        if (rst) sr_o <= '0;
        else     sr_o <= {sr_o[W-2:0], sd_i};
    end

endmodule

// File: rtl/pxd_frame_ctrl.sv
module pxd_frame_ctrl
    import pxd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_lost,
    input  logic              frame_start,
    input  logic [LSEL_W-1:0] lane_sel,
    output logic [LSEL_W-1:0] mode_o,
    output logic              full_o
);

    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    logic [CNT_W-1:0] n_bits;

    assign n_bits = bits_per_lane(mode_o);

    always_ff @(posedge clk) begin
        if (rst || clk_lost) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
            full_o <= 1'b0;
            mode_o <= '0;
        end else begin
            full_o <= 1'b0;
            if (frame_start) begin
                // first bit sampled on this edge; lane count latched here
                mode_o <= mode_of(lane_sel);
                cnt_q  <= CNT_W'(1);
                busy_q <= 1'b1;
            end else if (busy_q) begin
                if (cnt_q == n_bits - 1'b1) begin
                    busy_q <= 1'b0;
                    full_o <= 1'b1;
                    cnt_q  <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/pxd_frame_map.sv
module pxd_frame_map
    import pxd_pkg::*;
(
    input  logic [TOT_LANE_BITS-1:0] lanes_i,
    input  logic [LSEL_W-1:0]        mode_i,
    output frame_t                   frame_o
);

    logic [MAX_LANES-1:0][FRAME_W-1:0] cand;

    for (genvar m = 0; m < MAX_LANES; m++) begin : g_mode
        localparam int N = FRAME_W / (m + 1);
        frame_t c;
        always_comb begin
            for (int i = 0; i < FRAME_W; i++)
                c[i] = lanes_i[lane_off(i / N) + (i % N)];
        end
        assign cand[m] = c;
    end

    always_comb begin
        frame_o = cand[0];
        for (int m = 1; m < MAX_LANES; m++)
            if (int'(mode_i) == m) frame_o = cand[m];
    end

endmodule

// File: rtl/pxd_out_stage.sv
module pxd_out_stage
    import pxd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clk_lost,
    input  logic             full_i,
    input  frame_t           frame_i,
    input  logic             swap,
    output logic [PIX_W-1:0] pix_out,
    output logic             vs,
    output logic             hs,
    output logic             de,
    output logic             pclk_en,
    output logic             parity_err
);

    word_t word_q;
    logic  ok;

    assign ok = frame_ok(frame_i);

    always_ff @(posedge clk) begin
        if (rst || clk_lost) begin
            word_q     <= IDLE_WORD;
            parity_err <= 1'b0;
            pclk_en    <= 1'b0;
        end else begin
            pclk_en <= full_i;
            if (full_i) begin
                parity_err <= !ok;
                if (ok) word_q <= decode(frame_i);
            end
        end
    end

    assign pix_out = swap ? mirror(word_q.rgb) : word_q.rgb;
    assign vs      = word_q.vs;
    assign hs      = word_q.hs;
    assign de      = word_q.de;

endmodule

// File: rtl/pxd_deserializer.sv
module pxd_deserializer
    import pxd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clk_lost,
    input  logic [LSEL_W-1:0]    lane_sel,
    input  logic                 frame_start,
    input  logic [MAX_LANES-1:0] sd,
    input  logic                 swap,
    output logic [PIX_W-1:0]     pix_out,
    output logic                 vs,
    output logic                 hs,
    output logic                 de,
    output logic                 pclk_en,
    output logic                 parity_err
);

    logic [TOT_LANE_BITS-1:0] lanes_flat;
    logic [LSEL_W-1:0]        mode;
    logic                     full;
    frame_t                   frame;

    // Lane k only ever holds FRAME_W/(k+1) bits
    for (genvar k = 0; k < MAX_LANES; k++) begin : g_lane
        localparam int LW  = FRAME_W / (k + 1);
        localparam int OFF = lane_off(k);
        pxd_lane_shift #(.W(LW)) u_shift (
            .clk  (clk),
            .rst  (rst),
            .sd_i (sd[k]),
            .sr_o (lanes_flat[OFF +: LW])
        );
    end

    pxd_frame_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .clk_lost    (clk_lost),
        .frame_start (frame_start),
        .lane_sel    (lane_sel),
        .mode_o      (mode),
        .full_o      (full)
    );

    pxd_frame_map u_map (
        .lanes_i (lanes_flat),
        .mode_i  (mode),
        .frame_o (frame)
    );

    pxd_out_stage u_out (
        .clk        (clk),
        .rst        (rst),
        .clk_lost   (clk_lost),
        .full_i     (full),
        .frame_i    (frame),
        .swap       (swap),
        .pix_out    (pix_out),
        .vs         (vs),
        .hs         (hs),
        .de         (de),
        .pclk_en    (pclk_en),
        .parity_err (parity_err)
    );

endmodule

// File: rtl/pxd_deserializer_chk.sv
module pxd_deserializer_chk
    import pxd_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             clk_lost,
    input logic             swap,
    input logic [PIX_W-1:0] pix_out,
    input logic             vs,
    input logic             hs,
    input logic             de,
    input logic             pclk_en,
    input logic             parity_err
);

    // R4: pixel strobe lasts one cycle
    a_r4_pclk_single: assert property (@(posedge clk) disable iff (rst)
        pclk_en |=> !pclk_en);

    // R6: idle pattern one edge after clock loss
    a_r6_idle: assert property (@(posedge clk) disable iff (rst)
        $past(clk_lost) |-> (!pclk_en && !de && !parity_err && vs && hs && (&pix_out)));

    // R3: an errored frame leaves the word untouched
    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        (pclk_en && parity_err && $stable(swap)) |-> $stable({pix_out, vs, hs, de}));

    // R3: error flag moves only with a pixel strobe or clock loss
    a_r3_err_steady: assert property (@(posedge clk) disable iff (rst)
        (!pclk_en && !$past(clk_lost)) |-> $stable(parity_err));

    // R10: state right after reset
    a_r10_reset_idle: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!pclk_en && !de && !parity_err && vs && hs && (&pix_out)));

endmodule

bind pxd_deserializer pxd_deserializer_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .clk_lost   (clk_lost),
    .swap       (swap),
    .pix_out    (pix_out),
    .vs         (vs),
    .hs         (hs),
    .de         (de),
    .pclk_en    (pclk_en),
    .parity_err (parity_err)
);

// File: tb/pxd_deserializer_test.sv
module pxd_deserializer_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        clk_lost;
    logic [1:0]  lane_sel;
    logic        frame_start;
    logic [2:0]  sd;
    logic        swap;
    logic [23:0] pix_out;
    logic        vs, hs, de, pclk_en, parity_err;

    int checks = 0;
    int fails  = 0;
    int pulses = 0;
    bit done   = 0;

    logic [26:0] exp_w;
    logic        exp_err;
    localparam logic [26:0] IDLE_W = {3'b110, 24'hFFFFFF};

    always #(CLK_PERIOD/2) clk = ~clk;

    pxd_deserializer uut (
        .clk(clk), .rst(rst), .clk_lost(clk_lost), .lane_sel(lane_sel),
        .frame_start(frame_start), .sd(sd), .swap(swap), .pix_out(pix_out),
        .vs(vs), .hs(hs), .de(de), .pclk_en(pclk_en), .parity_err(parity_err)
    );

    always @(negedge clk) if (pclk_en === 1'b1) pulses++;

    function automatic logic [23:0] rev24(input logic [23:0] x);
        logic [23:0] r;
        for (int i = 0; i < 24; i++) r[i] = x[23-i];
        return r;
    endfunction

    // w = {vs, hs, de, rgb}; parity makes bits 27:0 even; bit29=1, bit28=0
    function automatic logic [29:0] make_frame(input logic [26:0] w, input logic bad_par,
                                               input logic bad_mark);
        logic [29:0] f;
        f[26:0] = w;
        f[27]   = (^w) ^ bad_par;
        f[28]   = bad_mark;
        f[29]   = 1'b1;
        return f;
    endfunction

    task automatic check(input logic ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic expect_outputs(input string req);
        logic [23:0] ep;
        ep = swap ? rev24(exp_w[23:0]) : exp_w[23:0];
        check(pix_out === ep, req, "pix_out", {8'h0, pix_out}, {8'h0, ep});
        check({vs, hs, de} === exp_w[26:24], req, "vs/hs/de",
              {29'h0, vs, hs, de}, {29'h0, exp_w[26:24]});
        check(parity_err === exp_err, req, "parity_err", {31'h0, parity_err}, {31'h0, exp_err});
    endtask

    task automatic send_frame(input logic [1:0] sel, input logic [1:0] sel_mid,
                              input logic [29:0] f);
        int nl, n;
        nl = (sel == 2'b00) ? 1 : (sel == 2'b01) ? 2 : 3;
        n  = 30 / nl;
        for (int t = 0; t < n; t++) begin
            @(negedge clk);
            frame_start = (t == 0);
            lane_sel    = (t == 0) ? sel : sel_mid;
            for (int k = 0; k < 3; k++) begin
                if (k < nl) sd[k] = f[k*n + n - 1 - t];
                else        sd[k] = 1'($urandom % 2);
            end
        end
        @(negedge clk);
        frame_start = 1'b0;
        lane_sel    = sel_mid;
    endtask

    task automatic do_frame(input logic [1:0] sel, input logic [1:0] sel_mid,
                            input logic [26:0] w, input logic bad_par, input logic bad_mark,
                            input logic swp, input string req);
        swap = swp;
        send_frame(sel, sel_mid, make_frame(w, bad_par, bad_mark));
        @(negedge clk);
        if (bad_par || bad_mark) exp_err = 1'b1;
        else begin exp_err = 1'b0; exp_w = w; end
        check(pclk_en === 1'b1, "R4", "pclk_en at latch", {31'h0, pclk_en}, 32'h1);
        expect_outputs(req);
        @(negedge clk);
        check(pclk_en === 1'b0, "R4", "pclk_en width", {31'h0, pclk_en}, 32'h0);
    endtask

    initial begin
        int seed;
        int p0;
        seed = $urandom(32'h1D5EED);
        rst = 1'b1; clk_lost = 1'b0; lane_sel = 2'b00; frame_start = 1'b0;
        sd = 3'b000; swap = 1'b0;
        exp_w = IDLE_W; exp_err = 1'b0;
        repeat (3) @(negedge clk);
        // R10: reset state
        expect_outputs("R10");
        check(pclk_en === 1'b0, "R10", "pclk_en in reset", {31'h0, pclk_en}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        expect_outputs("R10");

        // R1 / R2: each lane code with a directed word
        do_frame(2'b00, 2'b00, {3'b011, 24'h123456}, 0, 0, 0, "R1");
        do_frame(2'b01, 2'b01, {3'b101, 24'hA5C3F0}, 0, 0, 0, "R1");
        do_frame(2'b10, 2'b10, {3'b111, 24'h0F1E2D}, 0, 0, 0, "R1");
        do_frame(2'b11, 2'b11, {3'b001, 24'h80C001}, 0, 0, 0, "R1");

        // R3: damaged frames hold the word, a good one clears the flag
        do_frame(2'b01, 2'b01, {3'b000, 24'hDEAD00}, 1, 0, 0, "R3");
        do_frame(2'b10, 2'b10, {3'b010, 24'h00BEEF}, 0, 1, 0, "R3");
        do_frame(2'b00, 2'b00, {3'b100, 24'h5A5A5A}, 0, 0, 0, "R2");

        // R5: swap is combinational and leaves controls alone
        swap = 1'b1; #1;
        expect_outputs("R5");
        swap = 1'b0; #1;
        expect_outputs("R5");

        // R8: lane select changes after the strobe
        do_frame(2'b00, 2'b10, {3'b110, 24'h13579B}, 0, 0, 0, "R8");
        do_frame(2'b10, 2'b01, {3'b011, 24'h2468AC}, 0, 0, 1, "R8");

        // R9: strobe during collection restarts the frame
        p0 = pulses;
        @(negedge clk); frame_start = 1'b1; lane_sel = 2'b01; sd = 3'b111;
        for (int i = 0; i < 7; i++) begin
            @(negedge clk); frame_start = 1'b0; sd = 3'($urandom);
        end
        do_frame(2'b01, 2'b01, {3'b001, 24'hC0FFEE}, 0, 0, 0, "R9");
        check(pulses - p0 == 1, "R9", "pulse count", 32'(pulses - p0), 32'h1);

        // R6: clock loss forces idle, strobes ignored
        @(negedge clk); clk_lost = 1'b1; swap = 1'b1;
        @(negedge clk);
        exp_w = IDLE_W; exp_err = 1'b0;
        expect_outputs("R6");
        check(pclk_en === 1'b0, "R6", "pclk_en idle", {31'h0, pclk_en}, 32'h0);
        p0 = pulses;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk); frame_start = (i % 10 == 0); sd = 3'($urandom);
        end
        @(negedge clk); frame_start = 1'b0;
        expect_outputs("R6");
        check(pulses == p0, "R6", "no pulse while lost", 32'(pulses - p0), 32'h0);

        // R7: bits without a strobe after recovery give no pulse
        clk_lost = 1'b0; swap = 1'b0;
        p0 = pulses;
        for (int i = 0; i < 45; i++) begin
            @(negedge clk); sd = 3'($urandom);
        end
        @(negedge clk);
        check(pulses == p0, "R7", "no pulse before frame", 32'(pulses - p0), 32'h0);
        expect_outputs("R7");
        do_frame(2'b10, 2'b10, {3'b111, 24'h010203}, 0, 0, 0, "R7");

        // Random mix across modes, swap and damage
        for (int i = 0; i < 60; i++) begin
            logic [1:0] sel;
            int r;
            logic [26:0] w;
            logic swp;
            sel = 2'($urandom % 4);
            r   = int'($urandom % 6);
            w   = 27'($urandom);
            swp = 1'($urandom % 2);
            do_frame(sel, sel, w, r == 0, r == 1, swp, (r < 2) ? "R3" : "R2");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule